// File: doc/BRIEF.md
# System-control coprocessor: exception entry and return

This block holds the four control registers that a small 32-bit RISC core needs to take and leave exceptions: a status word, a cause word, the saved exception program counter and a programmable handler base. Software reaches them through a register port addressed by an index and a selector. The pipeline presents one cycle's worth of exception requests, the PC of the instruction in question, a flag that says whether that instruction sits in a branch delay slot, and a strobe for the return-from-exception instruction.

When a request is accepted, the unit records a five-bit cause code in bits 6:2 of the cause word. The code is therefore already multiplied by four, and a handler can use the masked cause word directly as a byte offset into a table of 32-bit words. The unit also saves the restart address, raises the exception level bit, and on the next cycle presents a one-cycle redirect with the handler address. The handler address comes from a fixed vector, from the programmable base, or from a per-line interrupt slot above that base. The return strobe lowers the error level bit, or the exception level bit when the error level bit is already clear, and redirects to the saved PC.

Top module: `cp0_exc_unit`

## Requirements
- R1: After reset, status reads 0x00400004 (bit 22 BEV and bit 2 ERL set), cause reads 0, EPC reads 0, the base register reads 0x80000000, `kernel_mode_o` is 1 and `redirect_o` is 0.
- R2: Status is at index 12 selector 0, cause at 13/0, EPC at 14/0 and the base register at 15/1. Any other index/selector pair reads 0, and a write to it changes no register.
- R3: Status keeps only bit 22 (BEV), bits 15:8 (interrupt mask), bit 2 (ERL), bit 1 (EXL) and bit 0 (IE) from a write. Every other bit reads 0. `kernel_mode_o` equals EXL OR ERL.
- R4: Of the cause word, a write changes only bit 23 (vectored-interrupt select). Bit 31 (delay-slot flag), bits 15:8 (pending lines) and bits 6:2 (code) ignore writes. Bits 15:8 show `irq_lines_i` as sampled at the previous clock edge. The base register keeps write bits 29:12 and always reads bit 31 as 1, bit 30 as 0 and bits 11:0 as 0.
- R5: An accepted exception sets EXL at the next edge. In the cycle after acceptance, `redirect_o` is high for exactly that one cycle and `kernel_mode_o` is 1.
- R6: The code written to cause[6:2] is 0 for an interrupt, 6 for `exc_req_i[0]` (fetch bus error), 10 for [1] (reserved instruction), 11 for [2] (coprocessor unusable), 8 for [3] (syscall), 9 for [4] (breakpoint), 12 for [5] (overflow), 4 for [6] (unaligned load), 5 for [7] (unaligned store) and 7 for [8] (data bus error).
- R7: When several causes are present in one cycle, an accepted interrupt wins. Otherwise the lowest set bit of `exc_req_i` wins.
- R8: An interrupt is accepted only when IE=1, EXL=0, ERL=0 and `irq_lines_i` AND the interrupt mask is non-zero.
- R9: On entry with EXL=0, EPC receives `pc_i`, or `pc_i`-4 when `in_delay_i` is 1, and cause bit 31 receives `in_delay_i`. A syscall therefore saves its own address. With EXL=1, neither EPC nor cause bit 31 changes.
- R10: With BEV=0 and IV=0, the redirect target is 0x80000180. Otherwise it is base+0x180. The exception is an accepted interrupt with IV=1: its target is base+0x200+256×(highest pending-and-unmasked line number). The mode is taken from register values before any write in the same cycle.
- R11: A return strobe with no accepted exception clears ERL if ERL is set, and otherwise clears EXL. In the next cycle it drives `redirect_o` with the EPC value held when the strobe was seen. An accepted exception in the same cycle overrides the return.
- R12: A register write in the same cycle as an exception entry is applied first. The entry then overrides EXL, the code, and (when EXL was 0) EPC and cause bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 8 | Interrupt request lines |
| exc_req_i | input | 9 | Synchronous exception requests, bit order as in R6 |
| pc_i | input | 32 | PC of the instruction raising the request |
| in_delay_i | input | 1 | That instruction is in a branch delay slot |
| eret_i | input | 1 | Return-from-exception strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_idx_i | input | 5 | Register index |
| reg_sel_i | input | 3 | Register selector |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| redirect_o | output | 1 | Fetch redirect valid |
| redirect_pc_o | output | 32 | Fetch redirect target |
| kernel_mode_o | output | 1 | Privileged mode |

## Verification
Exception entry can coincide with a software register write, and it can also coincide with a return strobe. The bench raises both pairings on purpose. It writes status, or writes EPC, in the very cycle a request arrives. It also asserts the return strobe together with a request, while EXL is either clear or set. A long random phase then lets all three collide freely. A behavioural model encodes the precedence stated in R11 and R12, and every clock it is compared on the redirect, the target, the mode flag and the read data.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  localparam int NUM_IRQ  = 8;
  localparam int NUM_SYNC = 9;
  localparam int IRQ_W    = $clog2(NUM_IRQ);
  localparam int CODE_W   = 5;

  localparam logic [4:0] IDX_STATUS = 5'd12;
  localparam logic [4:0] IDX_CAUSE  = 5'd13;
  localparam logic [4:0] IDX_EPC    = 5'd14;
  localparam logic [4:0] IDX_EBASE  = 5'd15;
  localparam logic [2:0] SEL_STATUS = 3'd0;
  localparam logic [2:0] SEL_CAUSE  = 3'd0;
  localparam logic [2:0] SEL_EPC    = 3'd0;
  localparam logic [2:0] SEL_EBASE  = 3'd1;

  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_BEV = 22;
  localparam int CA_CODE_LO = 2;
  localparam int CA_IP_LO   = 8;
  localparam int CA_IV      = 23;
  localparam int CA_BD      = 31;
  localparam int ST_IM_LO   = 8;

  localparam logic [31:0] STATUS_WMASK = 32'h0040_FF07;
  localparam logic [31:0] STATUS_RST   = 32'h0040_0004;
  localparam logic [31:0] CAUSE_WMASK  = 32'h0080_0000;
  localparam logic [31:0] EBASE_WMASK  = 32'h3FFF_F000;
  localparam logic [31:0] EBASE_FIXED  = 32'h8000_0000;

  typedef enum logic [CODE_W-1:0] {
    EXC_INT  = 5'd0,
    EXC_ADEL = 5'd4,
    EXC_ADES = 5'd5,
    EXC_IBE  = 5'd6,
    EXC_DBE  = 5'd7,
    EXC_SYS  = 5'd8,
    EXC_BP   = 5'd9,
    EXC_RI   = 5'd10,
    EXC_CPU  = 5'd11,
    EXC_OV   = 5'd12
  } exc_code_e;

  // request bit positions; lower index = higher priority
  localparam int REQ_IBE  = 0;
  localparam int REQ_RI   = 1;
  localparam int REQ_CPU  = 2;
  localparam int REQ_SYS  = 3;
  localparam int REQ_BP   = 4;
  localparam int REQ_OV   = 5;
  localparam int REQ_ADEL = 6;
  localparam int REQ_ADES = 7;
  localparam int REQ_DBE  = 8;

  function automatic exc_code_e req_code(input int idx);
    case (idx)
      REQ_IBE:  return EXC_IBE;
      REQ_RI:   return EXC_RI;
      REQ_CPU:  return EXC_CPU;
      REQ_SYS:  return EXC_SYS;
      REQ_BP:   return EXC_BP;
      REQ_OV:   return EXC_OV;
      REQ_ADEL: return EXC_ADEL;
      REQ_ADES: return EXC_ADES;
      default:  return EXC_DBE;
    endcase
  endfunction
endpackage

// File: rtl/cp0_exc_prio.sv
module cp0_exc_prio
  import cp0_pkg::*;
#(
  parameter int NSYNC = NUM_SYNC,
  parameter int NIRQ  = NUM_IRQ,
  parameter int LW    = $clog2(NIRQ)
) (
  input  logic             irq_en_i,
  input  logic [NIRQ-1:0]  irq_hit_i,
  input  logic [NSYNC-1:0] sync_i,
  output logic             take_o,
  output logic             is_irq_o,
  output exc_code_e        code_o,
  output logic [LW-1:0]    line_o
);
  logic sync_any;
  logic irq_take;
  exc_code_e sync_code;

  assign irq_take = irq_en_i & (|irq_hit_i);

  // scan from lowest priority so the highest-priority hit is assigned last
  always_comb begin
    sync_any  = 1'b0;
    sync_code = EXC_DBE;
    for (int k = NSYNC - 1; k >= 0; k--) begin
      if (sync_i[k]) begin
        sync_any  = 1'b1;
        sync_code = req_code(k);
      end
    end
  end

  always_comb begin
    line_o = '0;
    for (int k = 0; k < NIRQ; k++) begin
      if (irq_hit_i[k]) line_o = LW'(k);
    end
  end

  assign take_o   = irq_take | sync_any;
  assign is_irq_o = irq_take;
  assign code_o   = irq_take ? EXC_INT : sync_code;
endmodule

// File: rtl/cp0_vec_sel.sv
module cp0_vec_sel #(
  parameter logic [31:0] FIXED_VEC = 32'h8000_0180,
  parameter int          GEN_OFS   = 32'h180,
  parameter int          VINT_OFS  = 32'h200,
  parameter int          SLOT      = 256,
  parameter int          NIRQ      = 8,
  parameter int          LW        = $clog2(NIRQ)
) (
  input  logic          bev_i,
  input  logic          iv_i,
  input  logic          is_irq_i,
  input  logic [LW-1:0] line_i,
  input  logic [31:0]   base_i,
  output logic [31:0]   target_o
);
  logic [31:0] gen_tgt;
  logic [31:0] vint_tgt;

  assign gen_tgt  = base_i + 32'(GEN_OFS);
  assign vint_tgt = base_i + 32'(VINT_OFS) + (32'(line_i) * 32'(SLOT));

  always_comb begin
    if (!bev_i && !iv_i)      target_o = FIXED_VEC;
    else if (is_irq_i && iv_i) target_o = vint_tgt;
    else                       target_o = gen_tgt;
  end
endmodule

// File: rtl/cp0_exc_unit.sv
module cp0_exc_unit
  import cp0_pkg::*;
#(
  parameter logic [31:0] FIXED_VEC = 32'h8000_0180,
  parameter logic [31:0] EBASE_RST = 32'h8000_0000,
  parameter int          VEC_SLOT  = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_IRQ-1:0]  irq_lines_i,
  input  logic [NUM_SYNC-1:0] exc_req_i,
  input  logic [31:0]         pc_i,
  input  logic                in_delay_i,
  input  logic                eret_i,
  input  logic                reg_we_i,
  input  logic [4:0]          reg_idx_i,
  input  logic [2:0]          reg_sel_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                redirect_o,
  output logic [31:0]         redirect_pc_o,
  output logic                kernel_mode_o
);
  localparam logic [31:0] EBASE_INIT = EBASE_FIXED | (EBASE_RST & EBASE_WMASK);

  logic [31:0] status_q, status_d;
  logic [31:0] cause_q, cause_d;
  logic [31:0] epc_q, epc_d;
  logic [31:0] ebase_q, ebase_d;
  logic        redir_d;
  logic [31:0] redir_pc_d;

  logic hit_status, hit_cause, hit_epc, hit_ebase;
  logic wr_status, wr_cause, wr_epc, wr_ebase;

  logic             irq_en;
  logic [NUM_IRQ-1:0] irq_hit;
  logic             exc_take;
  logic             exc_is_irq;
  exc_code_e        exc_code;
  logic [IRQ_W-1:0] irq_line;
  logic [31:0]      vec_target;

  assign hit_status = (reg_idx_i == IDX_STATUS) && (reg_sel_i == SEL_STATUS);
  assign hit_cause  = (reg_idx_i == IDX_CAUSE)  && (reg_sel_i == SEL_CAUSE);
  assign hit_epc    = (reg_idx_i == IDX_EPC)    && (reg_sel_i == SEL_EPC);
  assign hit_ebase  = (reg_idx_i == IDX_EBASE)  && (reg_sel_i == SEL_EBASE);
  assign wr_status  = reg_we_i && hit_status;
  assign wr_cause   = reg_we_i && hit_cause;
  assign wr_epc     = reg_we_i && hit_epc;
  assign wr_ebase   = reg_we_i && hit_ebase;

  assign irq_en  = status_q[ST_IE] & ~status_q[ST_EXL] & ~status_q[ST_ERL];
  assign irq_hit = irq_lines_i & status_q[ST_IM_LO +: NUM_IRQ];

  cp0_exc_prio #(
    .NSYNC (NUM_SYNC),
    .NIRQ  (NUM_IRQ),
    .LW    (IRQ_W)
  ) u_prio (
    .irq_en_i  (irq_en),
    .irq_hit_i (irq_hit),
    .sync_i    (exc_req_i),
    .take_o    (exc_take),
    .is_irq_o  (exc_is_irq),
    .code_o    (exc_code),
    .line_o    (irq_line)
  );

  cp0_vec_sel #(
    .FIXED_VEC (FIXED_VEC),
    .SLOT      (VEC_SLOT),
    .NIRQ      (NUM_IRQ),
    .LW        (IRQ_W)
  ) u_vec (
    .bev_i    (status_q[ST_BEV]),
    .iv_i     (cause_q[CA_IV]),
    .is_irq_i (exc_is_irq),
    .line_i   (irq_line),
    .base_i   (ebase_q),
    .target_o (vec_target)
  );

  // software write first, hardware entry/return overrides
  always_comb begin
    status_d   = status_q;
    cause_d    = cause_q;
    epc_d      = epc_q;
    ebase_d    = ebase_q;
    redir_d    = 1'b0;
    redir_pc_d = redirect_pc_o;

    if (wr_status) status_d = reg_wdata_i & STATUS_WMASK;
    if (wr_cause)  cause_d  = (reg_wdata_i & CAUSE_WMASK) | (cause_q & ~CAUSE_WMASK);
    if (wr_epc)    epc_d    = reg_wdata_i;
    if (wr_ebase)  ebase_d  = EBASE_FIXED | (reg_wdata_i & EBASE_WMASK);

    cause_d[CA_IP_LO +: NUM_IRQ] = irq_lines_i;

    if (exc_take) begin
      status_d[ST_EXL] = 1'b1;
      cause_d[CA_CODE_LO +: CODE_W] = exc_code;
      if (!status_q[ST_EXL]) begin
        epc_d          = in_delay_i ? (pc_i - 32'd4) : pc_i;
        cause_d[CA_BD] = in_delay_i;
      end
      redir_d    = 1'b1;
      redir_pc_d = vec_target;
    end else if (eret_i) begin
      if (status_q[ST_ERL]) status_d[ST_ERL] = 1'b0;
      else                  status_d[ST_EXL] = 1'b0;
      redir_d    = 1'b1;
      redir_pc_d = epc_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q      <= STATUS_RST;
      cause_q       <= '0;
      epc_q         <= '0;
      ebase_q       <= EBASE_INIT;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      status_q      <= status_d;
      cause_q       <= cause_d;
      epc_q         <= epc_d;
      ebase_q       <= ebase_d;
      redirect_o    <= redir_d;
      redirect_pc_o <= redir_pc_d;
    end
  end

  always_comb begin
    if (hit_status)     reg_rdata_o = status_q;
    else if (hit_cause) reg_rdata_o = cause_q;
    else if (hit_epc)   reg_rdata_o = epc_q;
    else if (hit_ebase) reg_rdata_o = ebase_q;
    else                reg_rdata_o = '0;
  end

  assign kernel_mode_o = status_q[ST_EXL] | status_q[ST_ERL];
endmodule

// File: rtl/cp0_exc_unit_chk.sv
module cp0_exc_unit_chk
  import cp0_pkg::*;
#(
  parameter logic [31:0] FIXED_VEC = 32'h8000_0180
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_SYNC-1:0] exc_req_i,
  input logic                eret_i,
  input logic                reg_we_i,
  input logic [4:0]          reg_idx_i,
  input logic [2:0]          reg_sel_i,
  input logic                redirect_o,
  input logic [31:0]         redirect_pc_o,
  input logic                kernel_mode_o,
  input logic                exc_take,
  input logic                exl,
  input logic                bev,
  input logic                iv,
  input logic [31:0]         epc_q
);
  logic epc_wr;
  assign epc_wr = reg_we_i && (reg_idx_i == IDX_EPC) && (reg_sel_i == SEL_EPC);

  p_entry_redirect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i != '0) |=> (redirect_o && kernel_mode_o));

  p_fixed_vector_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_take && !bev && !iv) |=> (redirect_pc_o == FIXED_VEC));

  p_return_target_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !exc_take) |=> (redirect_o && (redirect_pc_o == $past(epc_q))));

  p_epc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_take && exl && !epc_wr) |=> $stable(epc_q));

  p_no_irq_nested_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exl && (exc_req_i == '0) && !eret_i) |=> !redirect_o);

  p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_take && !eret_i) |=> !redirect_o);
endmodule

bind cp0_exc_unit cp0_exc_unit_chk #(.FIXED_VEC(FIXED_VEC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .exc_req_i     (exc_req_i),
  .eret_i        (eret_i),
  .reg_we_i      (reg_we_i),
  .reg_idx_i     (reg_idx_i),
  .reg_sel_i     (reg_sel_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .kernel_mode_o (kernel_mode_o),
  .exc_take      (exc_take),
  .exl           (status_q[ST_EXL]),
  .bev           (status_q[ST_BEV]),
  .iv            (cause_q[CA_IV]),
  .epc_q         (epc_q)
);

// File: tb/cp0_exc_unit_test.sv
`timescale 1ns/1ps
module cp0_exc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_lines = '0;
  logic [8:0]  exc_req = '0;
  logic [31:0] pc = '0;
  logic        in_delay = 1'b0;
  logic        eret = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  idx = '0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        redir;
  logic [31:0] redir_pc;
  logic        kmode;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cp0_exc_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(irq_lines), .exc_req_i(exc_req),
    .pc_i(pc), .in_delay_i(in_delay), .eret_i(eret), .reg_we_i(we),
    .reg_idx_i(idx), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .redirect_o(redir), .redirect_pc_o(redir_pc), .kernel_mode_o(kmode)
  );

  // behavioural reference state
  bit        m_bev, m_erl, m_exl, m_ie, m_iv, m_bd, m_redir;
  bit [7:0]  m_im, m_ip;
  bit [4:0]  m_code;
  bit [31:0] m_epc, m_ebase, m_rpc;
  bit [4:0]  codes [9] = '{5'd6, 5'd10, 5'd11, 5'd8, 5'd9, 5'd12, 5'd4, 5'd5, 5'd7};

  task automatic m_reset();
    m_bev = 1; m_erl = 1; m_exl = 0; m_ie = 0; m_iv = 0; m_bd = 0; m_redir = 0;
    m_im = 0; m_ip = 0; m_code = 0; m_epc = 0; m_ebase = 32'h8000_0000; m_rpc = 0;
  endtask

  function automatic bit [31:0] m_read(bit [4:0] i, bit [2:0] s);
    if (i == 12 && s == 0) return {9'd0, m_bev, 6'd0, m_im, 5'd0, m_erl, m_exl, m_ie};
    if (i == 13 && s == 0) return {m_bd, 7'd0, m_iv, 7'd0, m_ip, 1'b0, m_code, 2'b00};
    if (i == 14 && s == 0) return m_epc;
    if (i == 15 && s == 1) return m_ebase;
    return 32'd0;
  endfunction

  task automatic m_step();
    bit o_exl, o_erl, irq, take;
    bit [7:0] hit;
    int line;
    bit [4:0] code;
    bit [31:0] tgt, o_epc;
    o_exl = m_exl; o_erl = m_erl; o_epc = m_epc;
    hit = irq_lines & m_im;
    irq = m_ie && !o_exl && !o_erl && (hit != 0);
    line = 0;
    for (int k = 0; k < 8; k++) if (hit[k]) line = k;
    take = irq; code = 0;
    if (!irq) for (int k = 8; k >= 0; k--) if (exc_req[k]) begin take = 1; code = codes[k]; end
    if (!m_bev && !m_iv) tgt = 32'h8000_0180;
    else if (irq && m_iv) tgt = m_ebase + 32'h200 + 32'(line * 256);
    else tgt = m_ebase + 32'h180;
    if (we && idx == 12 && sel == 0) begin
      m_bev = wdata[22]; m_im = wdata[15:8]; m_erl = wdata[2]; m_exl = wdata[1]; m_ie = wdata[0];
    end
    if (we && idx == 13 && sel == 0) m_iv = wdata[23];
    if (we && idx == 14 && sel == 0) m_epc = wdata;
    if (we && idx == 15 && sel == 1) m_ebase = 32'h8000_0000 | (wdata & 32'h3FFF_F000);
    m_ip = irq_lines;
    m_redir = 0;
    if (take) begin
      m_exl = 1; m_code = code;
      if (!o_exl) begin m_epc = in_delay ? pc - 32'd4 : pc; m_bd = in_delay; end
      m_redir = 1; m_rpc = tgt;
    end else if (eret) begin
      if (o_erl) m_erl = 0; else m_exl = 0;
      m_redir = 1; m_rpc = o_epc;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic chk(bit ok, string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(redir === m_redir, "redirect", 32'(redir), 32'(m_redir));
    if (m_redir) chk(redir_pc === m_rpc, "target", redir_pc, m_rpc);
    chk(kmode === (m_exl | m_erl), "kernel", 32'(kmode), 32'(m_exl | m_erl));
    chk(rdata === m_read(idx, sel), "rdata", rdata, m_read(idx, sel));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (rst_n) compare();
  endtask

  task automatic wr(bit [4:0] i, bit [2:0] s, bit [31:0] d);
    we = 1; idx = i; sel = s; wdata = d;
    tick();
    we = 0;
  endtask

  task automatic rd(bit [4:0] i, bit [2:0] s);
    idx = i; sel = s;
    tick();
  endtask

  task automatic exc(bit [8:0] r, bit [31:0] p, bit d);
    exc_req = r; pc = p; in_delay = d;
    tick();
    exc_req = 0; in_delay = 0;
  endtask

  task automatic do_eret();
    eret = 1;
    tick();
    eret = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    cur_req = "R1";
    rd(12, 0); chk(rdata == 32'h0040_0004, "status reset", rdata, 32'h0040_0004);
    chk(kmode == 1'b1 && redir == 1'b0, "mode/redirect reset", {30'd0, kmode, redir}, 32'h2);
    rd(13, 0); rd(14, 0);
    rd(15, 1); chk(rdata == 32'h8000_0000, "base reset", rdata, 32'h8000_0000);
    // R2 unmapped addresses
    cur_req = "R2";
    wr(12, 1, 32'hFFFF_FFFF); wr(14, 2, 32'hFFFF_FFFF); wr(3, 0, 32'hFFFF_FFFF); wr(15, 0, 32'hFFFF_FFFF);
    rd(12, 1); chk(rdata == 0, "unmapped read", rdata, 0);
    rd(12, 0); rd(14, 0); rd(15, 1);
    // R3 status mask
    cur_req = "R3";
    wr(12, 0, 32'hFFFF_FFFF);
    rd(12, 0); chk(rdata == 32'h0040_FF07, "status mask", rdata, 32'h0040_FF07);
    wr(12, 0, 32'h0000_FF01); rd(12, 0);
    chk(kmode == 1'b0, "user mode", 32'(kmode), 0);
    // R4 cause read-only fields
    cur_req = "R4";
    wr(13, 0, 32'hFFFF_FFFF); rd(13, 0);
    chk(rdata == 32'h0080_0000, "cause write mask", rdata, 32'h0080_0000);
    wr(13, 0, 32'h0); wr(15, 1, 32'hFFFF_FFFF); rd(15, 1);
    chk(rdata == 32'hBFFF_F000, "base mask", rdata, 32'hBFFF_F000);
    wr(15, 1, 32'h0);
    // R5, R6, R10 each synchronous source alone, fixed vector
    cur_req = "R6";
    idx = 13; sel = 0;
    for (int k = 0; k < 9; k++) begin
      exc(9'(1 << k), 32'h0000_1000 + 32'(k * 4), 1'b0);
      chk(redir && redir_pc == 32'h8000_0180, "R5 R10 fixed entry", redir_pc, 32'h8000_0180);
      tick();
      do_eret();
    end
    // R7 priority combinations
    cur_req = "R7";
    exc(9'h1FF, 32'h100, 0); do_eret();
    exc(9'h1FE, 32'h104, 0); do_eret();
    exc(9'h1E0, 32'h108, 0); do_eret();
    exc(9'h1C0, 32'h10C, 0); do_eret();
    exc(9'h180, 32'h110, 0); do_eret();
    exc(9'h018, 32'h114, 0); do_eret();
    // R8 interrupt gating
    cur_req = "R8";
    wr(12, 0, 32'h0000_0001);
    irq_lines = 8'h04; tick(); tick();
    chk(redir == 1'b0, "masked line", 32'(redir), 0);
    wr(12, 0, 32'h0000_0400); tick();
    chk(redir == 1'b0, "IE clear", 32'(redir), 0);
    wr(12, 0, 32'h0000_0401); idx = 13; tick();
    chk(redir == 1'b1, "irq taken", 32'(redir), 1);
    exc(9'h020, 32'h200, 0); tick();
    chk(redir == 1'b0, "no nested irq", 32'(redir), 0);
    irq_lines = 0; do_eret();
    // R9 EPC rules
    cur_req = "R9";
    wr(12, 0, 32'h0);
    exc(9'h002, 32'h0000_1000, 1); rd(14, 0);
    chk(rdata == 32'h0000_0FFC, "delay slot epc", rdata, 32'h0000_0FFC);
    exc(9'h001, 32'h0000_2000, 0); rd(14, 0);
    chk(rdata == 32'h0000_0FFC, "epc held under EXL", rdata, 32'h0000_0FFC);
    rd(13, 0); do_eret();
    exc(9'h008, 32'h0000_0400, 0); rd(14, 0);
    chk(rdata == 32'h0000_0400, "syscall epc", rdata, 32'h0000_0400);
    do_eret();
    // R10 base and vectored targets
    cur_req = "R10";
    wr(15, 1, 32'h1234_5000);
    wr(12, 0, 32'h0040_2001);
    exc(9'h010, 32'h300, 0);
    chk(redir_pc == 32'h9234_5180, "base general", redir_pc, 32'h9234_5180);
    do_eret();
    wr(13, 0, 32'h0080_0000);
    irq_lines = 8'h21; tick();
    chk(redir_pc == 32'h9234_5700, "vectored line 5", redir_pc, 32'h9234_5700);
    irq_lines = 0; do_eret();
    wr(12, 0, 32'h0);
    exc(9'h004, 32'h304, 0); do_eret();
    wr(13, 0, 32'h0);
    // R11 return
    cur_req = "R11";
    wr(12, 0, 32'h0000_0006); rd(12, 0);
    do_eret(); chk(kmode == 1'b1, "ERL cleared first", 32'(kmode), 1);
    do_eret(); chk(kmode == 1'b0, "EXL cleared", 32'(kmode), 0);
    eret = 1; exc(9'h100, 32'h500, 0); eret = 0;
    chk(redir_pc == 32'h8000_0180, "entry beats return", redir_pc, 32'h8000_0180);
    eret = 1; exc(9'h040, 32'h504, 0); eret = 0;
    do_eret();
    // R12 write and entry together
    cur_req = "R12";
    we = 1; idx = 12; sel = 0; wdata = 32'h0000_0000;
    exc(9'h020, 32'h600, 0); we = 0;
    rd(12, 0); chk(rdata == 32'h0000_0002, "EXL forced", rdata, 32'h0000_0002);
    do_eret();
    we = 1; idx = 14; sel = 0; wdata = 32'hDEAD_0000;
    exc(9'h020, 32'h700, 0); we = 0;
    rd(14, 0); chk(rdata == 32'h0000_0700, "entry epc wins", rdata, 32'h0000_0700);
    we = 1; idx = 14; sel = 0; wdata = 32'hCAFE_0000;
    exc(9'h020, 32'h800, 0); we = 0;
    rd(14, 0); chk(rdata == 32'hCAFE_0000, "write under EXL", rdata, 32'hCAFE_0000);
    do_eret();
    // mixed random traffic
    cur_req = "R7 R11 R12 mixed";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 15);
      exc_req   = (r < 4) ? 9'($urandom) : 9'd0;
      irq_lines = (r == 5) ? 8'($urandom) : 8'd0;
      eret      = (r >= 12);
      pc        = {$urandom, 2'b00} >> 2 << 2;
      in_delay  = 1'($urandom);
      we        = ($urandom_range(0, 3) == 0);
      idx       = 5'(12 + $urandom_range(0, 3));
      sel       = 3'($urandom_range(0, 1));
      wdata     = $urandom;
      tick();
    end
    exc_req = 0; irq_lines = 0; eret = 0; we = 0;
    tick();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule